// File: doc/BRIEF.md
# Interrupt Ring Entry Writer

This block posts channel interrupt records into two circular rings that live in host memory, one for receive events and one for transmit events. Each ring has 128 slots of two 16-bit words. A record carries a 24-bit context-table entry address, a 7-bit descriptor index and a serviced flag. The block talks to memory through a simple word port: one request at a time, held until the memory acknowledges it.

A requester raises a post request with a direction, an address and an index. The block first reads the upper word of the slot that the direction's producer pointer selects. If the host has not yet cleared the serviced flag, the block writes nothing. It pulses a miss response tagged with the ring (0 receive, 1 transmit) and leaves the pointer where it was, so a later post retries the same slot. Otherwise it writes the lower word, then the upper word with the flag set. It then pulses done and advances that ring's pointer.

Top module: `intr_ring_poster`

## Requirements
- R1: After reset, post_done, post_miss and mem_req are low, and both producer pointers are 0, so the first post of each direction targets slot 0.
- R2: Every post begins with a read (mem_we=0) of the upper word of the target slot, at ring base + 2*slot + 1, before any write is issued.
- R3: A post to a free slot writes two words, lower first: address ring base + 2*slot gets ctx[15:0]; address ring base + 2*slot + 1 gets ctx[23:16] in bits [7:0], the descriptor index in bits [14:8] and 1 in bit 15 (serviced flag). After both writes, post_done pulses for one cycle.
- R4: If bit 15 of the word read under R2 is 1, the block issues no write and pulses post_miss for one cycle, with miss_is_tx = 0 for the receive ring and 1 for the transmit ring.
- R5: A producer pointer advances by one after each done on its ring and wraps from 127 to 0.
- R6: Receive posts (post_is_tx=0) use the ring at RX_BASE and transmit posts (post_is_tx=1) use the ring at TX_BASE. Each ring has its own pointer, and a post on one ring leaves the other ring's pointer unchanged.
- R7: Each accepted request gets exactly one response, either post_done or post_miss, never both in the same cycle. No new request is accepted until that response has been given.
- R8: A miss leaves both pointers unchanged, so the next post on that ring targets the same slot again.
- R9: Once mem_req is raised, mem_req, mem_we, mem_addr and mem_wdata stay stable until the cycle in which mem_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_req | input | 1 | Post request, held until done or miss |
| post_is_tx | input | 1 | 0 = receive ring, 1 = transmit ring |
| post_ctx_addr | input | 24 | Context-table entry address to record |
| post_desc_idx | input | 7 | Descriptor index to record |
| post_done | output | 1 | One-cycle pulse: record written |
| post_miss | output | 1 | One-cycle pulse: slot still occupied, nothing written |
| miss_is_tx | output | 1 | Ring tag of the miss (0 receive, 1 transmit) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | MEM_AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 16 | Read data |

## Verification
On every cycle the assertions check these points: done and miss never coincide; a held memory request keeps its fields stable; a miss only follows a read that returned a set flag; an upper-word write always carries the flag; a done only follows an acknowledged write; and a miss leaves both pointers untouched. Some behaviour only the bench's scenarios can show: the exact slot addresses and packed words, the independence of the two rings, retries hitting the same slot, and the wrap from slot 127 to slot 0. To show these, a behavioural model predicts every memory access and response and compares them with the design's on each clock.

// File: rtl/irw_pkg.sv
// Shared constants and types for the interrupt ring entry writer.
// Assumes a 16-bit memory word and fixed record field positions.
package irw_pkg;
    localparam int WORD_W   = 16;
    localparam int CTX_W    = 24;
    localparam int IDX_W    = 7;
    localparam int DEPTH    = 1 << IDX_W;
    localparam int FLAG_BIT = WORD_W - 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_WLO,
        S_WHI,
        S_DONE,
        S_MISS
    } seq_state_t;

    typedef struct packed {
        logic [CTX_W-1:0] ctx;
        logic [IDX_W-1:0] idx;
        logic             is_tx;
    } post_rec_t;
endpackage

// File: rtl/irw_ptr.sv
// Producer pointer for one ring: counts posted records modulo 2**IDX_W.
// Assumes adv is a single-cycle pulse given only after a completed post.
module irw_ptr #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    // Advance on each completed post; natural overflow gives the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= ptr + 1'b1;
    end

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr == {IDX_W{1'b1}}) |=> (ptr == '0)); // R5
endmodule

// File: rtl/irw_pack.sv
// Slot address and record word builder. Selects the ring by the latched
// direction and forms both word addresses and both record words.
// Assumes ring bases are even and each ring fits below 2**MEM_AW.
module irw_pack
    import irw_pkg::*;
#(
    parameter int               MEM_AW  = 16,
    parameter logic [MEM_AW-1:0] RX_BASE = 'h0100,
    parameter logic [MEM_AW-1:0] TX_BASE = 'h0200
) (
    input  post_rec_t         rec,
    input  logic [IDX_W-1:0]  ptr_rx,
    input  logic [IDX_W-1:0]  ptr_tx,
    output logic [MEM_AW-1:0] addr_lo,
    output logic [MEM_AW-1:0] addr_hi,
    output logic [WORD_W-1:0] word_lo,
    output logic [WORD_W-1:0] word_hi
);
    localparam int PAD_W = MEM_AW - IDX_W - 1;

    logic [IDX_W-1:0]  slot;
    logic [MEM_AW-1:0] base;
    logic [MEM_AW-1:0] offset;

    // Pick the ring base and slot for the latched direction.
    always_comb begin
        base = rec.is_tx ? TX_BASE : RX_BASE;
        slot = rec.is_tx ? ptr_tx : ptr_rx;
    end

    // Two words per slot: offset is twice the slot number.
    always_comb begin
        offset  = {{PAD_W{1'b0}}, slot, 1'b0};
        addr_lo = base + offset;
        addr_hi = base + offset + 1'b1;
    end

    // Record layout: low word = ctx[15:0]; high word = flag, index, ctx[23:16].
    always_comb begin
        word_lo = rec.ctx[WORD_W-1:0];
        word_hi = {1'b1, rec.idx, rec.ctx[CTX_W-1:WORD_W]};
    end
endmodule

// File: rtl/irw_seq.sv
// Post sequencer: latches a request, reads the slot's upper word, and
// either reports a miss or writes the two record words and reports done.
// Assumes the requester holds post_req until done/miss and the memory
// acknowledges each request with a one-cycle mem_ack.
module irw_seq
    import irw_pkg::*;
#(
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_req,
    input  logic              post_is_tx,
    input  logic [CTX_W-1:0]  post_ctx_addr,
    input  logic [IDX_W-1:0]  post_desc_idx,
    input  logic [MEM_AW-1:0] addr_lo,
    input  logic [MEM_AW-1:0] addr_hi,
    input  logic [WORD_W-1:0] word_lo,
    input  logic [WORD_W-1:0] word_hi,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output post_rec_t         rec,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              post_done,
    output logic              post_miss,
    output logic              miss_is_tx,
    output logic              adv_rx,
    output logic              adv_tx
);
    seq_state_t state;
    seq_state_t state_nx;
    logic       slot_busy;
    logic       unused_rdata;

    assign slot_busy    = mem_rdata[FLAG_BIT];
    assign unused_rdata = ^mem_rdata[FLAG_BIT-1:0];

    // Next-state selection for one post transaction.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (post_req) state_nx = S_READ;
            S_READ: if (mem_ack)  state_nx = slot_busy ? S_MISS : S_WLO;
            S_WLO:  if (mem_ack)  state_nx = S_WHI;
            S_WHI:  if (mem_ack)  state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            S_MISS: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // Capture request operands when a post is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rec <= '0;
        else if (state == S_IDLE && post_req)
            rec <= '{ctx: post_ctx_addr, idx: post_desc_idx, is_tx: post_is_tx};
    end

    // Memory port drive, decoded from state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_hi;
        mem_wdata = '0;
        unique case (state)
            S_READ: mem_req = 1'b1;
            S_WLO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = addr_lo;
                mem_wdata = word_lo;
            end
            S_WHI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = word_hi;
            end
            default: ;
        endcase
    end

    // Responses and pointer advance pulses.
    always_comb begin
        post_done  = (state == S_DONE);
        post_miss  = (state == S_MISS);
        miss_is_tx = (state == S_MISS) && rec.is_tx;
        adv_rx     = (state == S_DONE) && !rec.is_tx;
        adv_tx     = (state == S_DONE) && rec.is_tx;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata))); // R9
    AST_MISS_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        post_miss |-> $past(mem_req && mem_ack && !mem_we && mem_rdata[FLAG_BIT])); // R4
    AST_HI_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr == addr_hi) |-> mem_wdata[FLAG_BIT]); // R3
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        post_done |-> $past(mem_req && mem_ack && mem_we)); // R3
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !$past(mem_req)) |-> 1'b0); // R2
endmodule

// File: rtl/intr_ring_poster.sv
// Interrupt ring entry writer top: one sequencer, one record builder and a
// producer pointer per ring (receive, transmit), built by a generate loop.
// Assumes a single requester and a single word-wide memory port.
module intr_ring_poster
    import irw_pkg::*;
#(
    parameter int               MEM_AW  = 16,
    parameter logic [MEM_AW-1:0] RX_BASE = 'h0100,
    parameter logic [MEM_AW-1:0] TX_BASE = 'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_req,
    input  logic              post_is_tx,
    input  logic [23:0]       post_ctx_addr,
    input  logic [6:0]        post_desc_idx,
    output logic              post_done,
    output logic              post_miss,
    output logic              miss_is_tx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata
);
    localparam int N_RINGS = 2;

    post_rec_t         rec;
    logic [IDX_W-1:0]  ptr [N_RINGS];
    logic [N_RINGS-1:0] adv;
    logic [MEM_AW-1:0] addr_lo;
    logic [MEM_AW-1:0] addr_hi;
    logic [WORD_W-1:0] word_lo;
    logic [WORD_W-1:0] word_hi;

    for (genvar g = 0; g < N_RINGS; g++) begin : g_ring
        irw_ptr #(.IDX_W(IDX_W)) ptr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv[g]),
            .ptr   (ptr[g])
        );
    end

    irw_pack #(
        .MEM_AW  (MEM_AW),
        .RX_BASE (RX_BASE),
        .TX_BASE (TX_BASE)
    ) pack_i (
        .rec     (rec),
        .ptr_rx  (ptr[0]),
        .ptr_tx  (ptr[1]),
        .addr_lo (addr_lo),
        .addr_hi (addr_hi),
        .word_lo (word_lo),
        .word_hi (word_hi)
    );

    irw_seq #(.MEM_AW(MEM_AW)) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .post_req      (post_req),
        .post_is_tx    (post_is_tx),
        .post_ctx_addr (post_ctx_addr),
        .post_desc_idx (post_desc_idx),
        .addr_lo       (addr_lo),
        .addr_hi       (addr_hi),
        .word_lo       (word_lo),
        .word_hi       (word_hi),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .rec           (rec),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .post_done     (post_done),
        .post_miss     (post_miss),
        .miss_is_tx    (miss_is_tx),
        .adv_rx        (adv[0]),
        .adv_tx        (adv[1])
    );

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(post_done && post_miss)); // R7
    AST_MISS_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        post_miss |=> ($stable(ptr[0]) && $stable(ptr[1]))); // R8
    AST_RX_UNTOUCHED_BY_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (post_done && miss_is_tx == 1'b0 && rec.is_tx) |=> $stable(ptr[0])); // R6
endmodule

// File: tb/intr_ring_poster_tb_top.sv
module intr_ring_poster_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 16;
    localparam logic [15:0] RXB        = 16'h0100;
    localparam logic [15:0] TXB        = 16'h0200;
    localparam int          WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_req = 1'b0;
    logic        post_is_tx = 1'b0;
    logic [23:0] post_ctx_addr = '0;
    logic [6:0]  post_desc_idx = '0;
    logic        post_done, post_miss, miss_is_tx;
    logic        mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    intr_ring_poster #(.MEM_AW(AW), .RX_BASE(RXB), .TX_BASE(TXB)) dut_i (
        .clk(clk), .rst_n(rst_n), .post_req(post_req), .post_is_tx(post_is_tx),
        .post_ctx_addr(post_ctx_addr), .post_desc_idx(post_desc_idx),
        .post_done(post_done), .post_miss(post_miss), .miss_is_tx(miss_is_tx),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int lat = 0;
    int mp [2] = '{0, 0};           // model producer pointers
    logic [15:0] hmem [int];         // host memory
    int exp_we [$];
    int exp_addr [$];
    int exp_data [$];
    bit in_post = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] rd(input int a);
        return hmem.exists(a) ? hmem[a] : 16'h0000;
    endfunction

    // Memory responder with per-access comparison against the model.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (rst_n && mem_req) begin
                if (cnt >= lat) begin
                    cnt = 0;
                    if (exp_we.size() == 0) begin
                        chk(1'b0, "R4", "unexpected memory access", mem_addr, 0);
                    end else begin
                        int ew, ea, ed;
                        ew = exp_we.pop_front();
                        ea = exp_addr.pop_front();
                        ed = exp_data.pop_front();
                        chk(mem_we == ew[0], ew ? "R3" : "R2", "access kind", mem_we, ew);
                        chk(int'(mem_addr) == ea, "R6", "access address", mem_addr, ea);
                        if (ew) chk(int'(mem_wdata) == ed, "R3", "write data", mem_wdata, ed);
                    end
                    if (mem_we) hmem[int'(mem_addr)] = mem_wdata;
                    else mem_rdata = rd(int'(mem_addr));
                    mem_ack = 1'b1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Per-clock response check outside posts.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !in_post)
                chk(!post_done && !post_miss, "R7", "spurious response",
                    {post_done, post_miss}, 0);
        end
    end

    task automatic do_post(input bit tx, input logic [23:0] ctx, input logic [6:0] idx);
        int base, lo, hi, t;
        bit busy, got_done, got_miss;
        base = tx ? int'(TXB) : int'(RXB);
        lo = base + 2 * mp[tx];
        hi = lo + 1;
        busy = rd(hi)[15];
        exp_we.push_back(0); exp_addr.push_back(hi); exp_data.push_back(0);
        if (!busy) begin
            exp_we.push_back(1); exp_addr.push_back(lo); exp_data.push_back(int'(ctx[15:0]));
            exp_we.push_back(1); exp_addr.push_back(hi);
            exp_data.push_back(int'({1'b1, idx, ctx[23:16]}));
        end
        in_post = 1'b1;
        post_is_tx = tx; post_ctx_addr = ctx; post_desc_idx = idx; post_req = 1'b1;
        got_done = 0; got_miss = 0; t = 0;
        while (!got_done && !got_miss && t < 200) begin
            @(negedge clk);
            got_done = post_done;
            got_miss = post_miss;
            t++;
        end
        post_req = 1'b0;
        chk(!(got_done && got_miss), "R7", "both responses", {got_done, got_miss}, 0);
        if (busy) begin
            chk(got_miss, "R4", "miss expected", got_miss, 1);
            chk(miss_is_tx == tx, "R4", "miss ring tag", miss_is_tx, tx);
        end else begin
            chk(got_done, "R3", "done expected", got_done, 1);
            mp[tx] = (mp[tx] + 1) % 128;
        end
        chk(exp_we.size() == 0, busy ? "R4" : "R3", "accesses left",
            exp_we.size(), 0);
        exp_we.delete(); exp_addr.delete(); exp_data.delete();
        @(negedge clk);
        chk(!post_done && !post_miss, "R7", "response held", {post_done, post_miss}, 0);
        in_post = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!post_done && !post_miss && !mem_req, "R1", "reset outputs",
            {post_done, post_miss, mem_req}, 0);
        // R1 R2 R3: first receive post lands in slot 0
        do_post(0, 24'hABCDEF, 7'd5);
        // R6: transmit ring independent, slot 0 of its own ring
        do_post(1, 24'h123456, 7'd127);
        // R6 R5: receive pointer continues at slot 1
        lat = 2;
        do_post(0, 24'h00FF00, 7'd0);
        // R4 R8: occupied receive slot 2, miss twice, then succeed
        hmem[int'(RXB) + 5] = 16'h8000;
        do_post(0, 24'h111111, 7'd1);
        chk(mp[0] == 2, "R8", "model pointer held", mp[0], 2);
        do_post(0, 24'h222222, 7'd2);
        hmem[int'(RXB) + 5] = 16'h0000;
        do_post(0, 24'h333333, 7'd3);
        chk(rd(int'(RXB) + 4) == 16'h3333, "R8", "retried slot word", rd(int'(RXB) + 4), 16'h3333);
        // R4: transmit miss tagged 1
        hmem[int'(TXB) + 3] = 16'h8001;
        lat = 0;
        do_post(1, 24'h0A0B0C, 7'd9);
        chk(rd(int'(TXB) + 2) == 16'h0000, "R4", "no write on miss", rd(int'(TXB) + 2), 0);
        // R5: host services every receive slot, then fill the ring to wrap
        for (int s = 0; s < 128; s++) hmem[int'(RXB) + 2 * s + 1] = 16'h0000;
        for (int k = 0; k < 126; k++) begin
            lat = k % 3;
            do_post(0, 24'(k * 24'h010203), 7'(k));
        end
        chk(mp[0] == 1, "R5", "model wrapped", mp[0], 1);
        hmem[int'(RXB) + 1] = 16'h8000;
        hmem[int'(RXB) + 3] = 16'h0000;
        do_post(0, 24'hFEDCBA, 7'd77);
        chk(rd(int'(RXB) + 3) == 16'hCDFE, "R5", "wrapped slot 1 high word",
            rd(int'(RXB) + 3), 16'hCDFE);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule